// File: doc/BRIEF.md
# Pipelined Complex Multiplier with Dithered Rounding

This block multiplies two signed fixed-point complex numbers, A = ar + j·ai and B = br + j·bi, and returns the product narrowed to a chosen output width. The two full-precision results are formed first. They are the real part ar·br − ai·bi and the imaginary part ar·bi + ai·br. Each is held at BP = 2·W + 1 bits, where W is the operand width. Each result is then reduced to BR bits. The kept part is the top BR bits. The low D = BP − BR bits are discarded.

A parameter picks the reduction method, either plain truncation or rounding. Rounding adds a constant equal to one half minus one LSB of the kept part, plus a one-bit round carry, and then drops the low D bits. The carry settles only the exact-half case. It can come from outside, on bit 0 of a small control word that travels with each operand pair. That input can carry a dither source or a static level. A second parameter can instead derive the carry from the result itself, for round-toward-zero, round-away-from-zero or round-half-to-even. Operands and control arrive on valid-qualified streams with no backpressure. Each accepted sample produces one result after a fixed latency.

Top module: `cmult_dither`

## Requirements
- R1: The real output is derived from P = ar·br − ai·bi and the imaginary output from P = ar·bi + ai·br. Both are computed exactly in BP = 2·W + 1 bits with two's-complement arithmetic. The output is bits BP−1 down to D of the processed value. Results wrap, with no saturation.
- R2: A sample is accepted only on a rising edge where in_valid and ctl_valid are both high. A cycle with only one of them high produces no output.
- R3: For a sample accepted on edge N, out_valid is high for exactly the one cycle after edge N+3 in truncation mode, or after edge N+4 in rounding mode. Samples may be accepted on back-to-back edges.
- R4: With ROUND_EN = 0, the output equals P[BP−1:D], with nothing added.
- R5: With ROUND_EN = 1, the output is bits BP−1 down to D of P + (2^(D−1) − 1) + c, where c is the round carry. A discarded fraction below one half therefore rounds down and one above one half rounds up, whatever the value of c.
- R6: With ROUND_EN = 1, a discarded fraction of exactly one half (2^(D−1)) rounds up when c = 1 and down when c = 0.
- R7: With CARRY_SRC = CSRC_EXTERNAL, c is bit 0 of ctl_data from the same accepting edge, and it applies to both the real and the imaginary output. Bits 1 and up of ctl_data have no effect.
- R8: With CARRY_SRC = CSRC_TO_ZERO, each output's c is the sign bit P[BP−1] of its own result, so exact halves round toward zero.
- R9: With CARRY_SRC = CSRC_AWAY, each output's c is the inverse of P[BP−1], so exact halves round away from zero.
- R10: With CARRY_SRC = CSRC_EVEN, each output's c is P[D], the LSB of the kept part, so exact halves round to the even neighbour.
- R11: While rst is high at a rising edge, out_valid is low after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operand pair present |
| in_ar | input | W | Real part of A, signed |
| in_ai | input | W | Imaginary part of A, signed |
| in_br | input | W | Real part of B, signed |
| in_bi | input | W | Imaginary part of B, signed |
| ctl_valid | input | 1 | Control word present |
| ctl_data | input | CTL_W | Control word; bit 0 is the external round carry |
| out_valid | output | 1 | Result present |
| out_r | output | BR | Reduced real result |
| out_i | output | BR | Reduced imaginary result |

## Verification
The rounding properties assume D = BP − BR is at least 2, so that a discarded fraction and a half point both exist. The latency property assumes that the stimulus holds both valids low while rst is high. It also assumes that no sample is accepted in the first few edges after reset, before the pipeline has filled. The bench meets these conditions by using the default widths (D = 17) and keeping the inputs idle through reset. It then drives directed exact-half, just-below-half and just-above-half products of both signs, with the carry at both levels. These are followed by extreme operands, lone-valid cycles, and a long run of pseudo-random operands with random gaps and random upper control bits.

// File: rtl/cmult_pkg.sv
package cmult_pkg;

    // Where the round carry for an exact-half fraction comes from
    typedef enum logic [1:0] {
        CSRC_EXTERNAL = 2'd0,
        CSRC_TO_ZERO  = 2'd1,
        CSRC_AWAY     = 2'd2,
        CSRC_EVEN     = 2'd3
    } carry_src_e;

    // Bit of the control word that holds the external carry
    localparam int unsigned CTL_CARRY_BIT = 0;

    function automatic int unsigned full_width(input int unsigned w);
        return 2 * w + 1;
    endfunction

    // Choose the carry for one lane from the selected source
    function automatic logic pick_carry(
        input carry_src_e src,
        input logic       ext_c,
        input logic       sign_bit,
        input logic       kept_lsb
    );
        logic c;
        case (src)
            CSRC_TO_ZERO: c = sign_bit;
            CSRC_AWAY:    c = ~sign_bit;
            CSRC_EVEN:    c = kept_lsb;
            default:      c = ext_c;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cmult_core.sv
module cmult_core #(
    parameter int unsigned W     = 16,
    parameter int unsigned CTL_W = 8
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic                                         in_valid,
    input  logic signed [W-1:0]                          in_ar,
    input  logic signed [W-1:0]                          in_ai,
    input  logic signed [W-1:0]                          in_br,
    input  logic signed [W-1:0]                          in_bi,
    input  logic                                         ctl_valid,
    input  logic [CTL_W-1:0]                             ctl_data,
    output logic                                         s_valid,
    output logic signed [cmult_pkg::full_width(W)-1:0]   s_pr,
    output logic signed [cmult_pkg::full_width(W)-1:0]   s_pi,
    output logic                                         s_carry
);
    import cmult_pkg::*;

    localparam int unsigned BP = full_width(W);
    localparam int unsigned PW = 2 * W;
    localparam int unsigned NSTG = 3;

    typedef struct packed {
        logic signed [W-1:0] ar;
        logic signed [W-1:0] ai;
        logic signed [W-1:0] br;
        logic signed [W-1:0] bi;
        logic                carry;
    } opnd_t;

    typedef struct packed {
        logic signed [PW-1:0] rr;
        logic signed [PW-1:0] ii;
        logic signed [PW-1:0] ri;
        logic signed [PW-1:0] ir;
        logic                 carry;
    } prod_t;

    logic [NSTG-1:0] vld_q;
    opnd_t           opnd_q;
    prod_t           prod_q;
    logic signed [BP-1:0] pr_q, pi_q;
    logic            carry_q;
    logic            accept;
    logic            unused_ctl;

    assign accept     = in_valid && ctl_valid;
    assign unused_ctl = ^ctl_data;

    // valid travels alongside the data stages
    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= {vld_q[NSTG-2:0], accept};
    end

    // stage 1: capture operands and the carry of the same transfer
    always_ff @(posedge clk) begin
        opnd_q.ar    <= in_ar;
        opnd_q.ai    <= in_ai;
        opnd_q.br    <= in_br;
        opnd_q.bi    <= in_bi;
        opnd_q.carry <= ctl_data[CTL_CARRY_BIT];
    end

    // stage 2: four partial products at full width
    always_ff @(posedge clk) begin
        prod_q.rr    <= PW'($signed(opnd_q.ar)) * PW'($signed(opnd_q.br));
        prod_q.ii    <= PW'($signed(opnd_q.ai)) * PW'($signed(opnd_q.bi));
        prod_q.ri    <= PW'($signed(opnd_q.ar)) * PW'($signed(opnd_q.bi));
        prod_q.ir    <= PW'($signed(opnd_q.ai)) * PW'($signed(opnd_q.br));
        prod_q.carry <= opnd_q.carry;
    end

    // stage 3: combine into real and imaginary results of BP bits
    always_ff @(posedge clk) begin
        pr_q    <= BP'($signed(prod_q.rr)) - BP'($signed(prod_q.ii));
        pi_q    <= BP'($signed(prod_q.ri)) + BP'($signed(prod_q.ir));
        carry_q <= prod_q.carry;
    end

    assign s_valid = vld_q[NSTG-1];
    assign s_pr    = pr_q;
    assign s_pi    = pi_q;
    assign s_carry = carry_q;

    // R2: a lone valid never enters the pipeline
    p_lone_valid_r2: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && ctl_valid) |=> !vld_q[0]);

endmodule

// File: rtl/cmult_quant.sv
module cmult_quant #(
    parameter int unsigned           BP        = 33,
    parameter int unsigned           BR        = 16,
    parameter bit                    ROUND_EN  = 1'b1,
    parameter cmult_pkg::carry_src_e CARRY_SRC = cmult_pkg::CSRC_EXTERNAL
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [BP-1:0] in_pr,
    input  logic signed [BP-1:0] in_pi,
    input  logic                 in_carry,
    output logic                 out_valid,
    output logic [BR-1:0]        out_r,
    output logic [BR-1:0]        out_i
);
    import cmult_pkg::*;

    localparam int unsigned D     = BP - BR;
    localparam int unsigned LANES = 2;
    localparam logic [BP-1:0] RCONST = BP'((64'd1 << (D - 1)) - 64'd1);
    localparam logic [D-1:0]  HALF   = D'(64'd1 << (D - 1));

    logic [BP-1:0] lane_p [LANES];
    logic [BR-1:0] lane_q [LANES];
    logic          ov;

    assign lane_p[0] = in_pr;
    assign lane_p[1] = in_pi;

    generate
        if (ROUND_EN) begin : g_round
            logic [1:0]       rv_q;
            logic [LANES-1:0] c;
            logic [BP-1:0]    sum_q [LANES];
            logic             unused_low;

            always_comb begin
                for (int l = 0; l < LANES; l++)
                    c[l] = pick_carry(CARRY_SRC, in_carry, lane_p[l][BP-1], lane_p[l][D]);
            end

            always_ff @(posedge clk) begin
                if (rst) rv_q <= '0;
                else     rv_q <= {rv_q[0], in_valid};
            end

            // add constant plus carry, then keep the top BR bits
            always_ff @(posedge clk) begin
                for (int l = 0; l < LANES; l++) begin
                    sum_q[l]  <= lane_p[l] + RCONST + BP'(c[l]);
                    lane_q[l] <= sum_q[l][BP-1:D];
                end
            end

            assign ov         = rv_q[1];
            assign unused_low = ^{sum_q[0][D-1:0], sum_q[1][D-1:0]};

            for (genvar gl = 0; gl < LANES; gl++) begin : g_chk
                // R5: result is the kept part or one above it
                p_round_step_r5: assert property (@(posedge clk) disable iff (rst)
                    ov |-> (lane_q[gl] == $past(lane_p[gl][BP-1:D], 2)) ||
                           (lane_q[gl] == $past(lane_p[gl][BP-1:D], 2) + BR'(1)));
                // R5: below half always rounds down
                p_below_half_r5: assert property (@(posedge clk) disable iff (rst)
                    (ov && ($past(lane_p[gl][D-1:0], 2) < HALF)) |->
                        lane_q[gl] == $past(lane_p[gl][BP-1:D], 2));
                // R5: above half always rounds up
                p_above_half_r5: assert property (@(posedge clk) disable iff (rst)
                    (ov && ($past(lane_p[gl][D-1:0], 2) > HALF)) |->
                        lane_q[gl] == $past(lane_p[gl][BP-1:D], 2) + BR'(1));
                // R6: exact half follows the carry
                p_tie_carry_r6: assert property (@(posedge clk) disable iff (rst)
                    (ov && ($past(lane_p[gl][D-1:0], 2) == HALF)) |->
                        lane_q[gl] == $past(lane_p[gl][BP-1:D], 2) + BR'($past(c[gl], 2)));
            end
        end else begin : g_trunc
            logic tv_q;
            logic unused_low;

            always_ff @(posedge clk) begin
                if (rst) tv_q <= 1'b0;
                else     tv_q <= in_valid;
            end

            always_ff @(posedge clk) begin
                for (int l = 0; l < LANES; l++)
                    lane_q[l] <= lane_p[l][BP-1:D];
            end

            assign ov         = tv_q;
            assign unused_low = ^{lane_p[0][D-1:0], lane_p[1][D-1:0], in_carry};

            for (genvar gl = 0; gl < LANES; gl++) begin : g_chk
                // R4: truncation keeps the top bits unchanged
                p_trunc_slice_r4: assert property (@(posedge clk) disable iff (rst)
                    ov |-> lane_q[gl] == $past(lane_p[gl][BP-1:D]));
            end
        end
    endgenerate

    assign out_valid = ov;
    assign out_r     = lane_q[0];
    assign out_i     = lane_q[1];

endmodule

// File: rtl/cmult_dither.sv
module cmult_dither #(
    parameter int unsigned           W         = 16,
    parameter int unsigned           BR        = 16,
    parameter int unsigned           CTL_W     = 8,
    parameter bit                    ROUND_EN  = 1'b1,
    parameter cmult_pkg::carry_src_e CARRY_SRC = cmult_pkg::CSRC_EXTERNAL
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_ar,
    input  logic signed [W-1:0] in_ai,
    input  logic signed [W-1:0] in_br,
    input  logic signed [W-1:0] in_bi,
    input  logic                ctl_valid,
    input  logic [CTL_W-1:0]    ctl_data,
    output logic                out_valid,
    output logic [BR-1:0]       out_r,
    output logic [BR-1:0]       out_i
);
    import cmult_pkg::*;

    localparam int unsigned BP  = full_width(W);
    localparam int unsigned LAT = ROUND_EN ? 5 : 4;

    logic                 s_valid;
    logic signed [BP-1:0] s_pr, s_pi;
    logic                 s_carry;

    cmult_core #(.W(W), .CTL_W(CTL_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ar     (in_ar),
        .in_ai     (in_ai),
        .in_br     (in_br),
        .in_bi     (in_bi),
        .ctl_valid (ctl_valid),
        .ctl_data  (ctl_data),
        .s_valid   (s_valid),
        .s_pr      (s_pr),
        .s_pi      (s_pi),
        .s_carry   (s_carry)
    );

    cmult_quant #(
        .BP(BP), .BR(BR), .ROUND_EN(ROUND_EN), .CARRY_SRC(CARRY_SRC)
    ) u_quant (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (s_valid),
        .in_pr     (s_pr),
        .in_pi     (s_pi),
        .in_carry  (s_carry),
        .out_valid (out_valid),
        .out_r     (out_r),
        .out_i     (out_i)
    );

    // R3: every result traces back to an accepted transfer LAT edges earlier
    p_latency_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && ctl_valid, LAT));

    // R11: reset clears the output valid
    p_rst_quiet_r11: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: tb/tb_cmult_dither.sv
`timescale 1ns/1ps
module tb_cmult_dither;
    import cmult_pkg::*;

    localparam int NDUT = 5;
    localparam int RING = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, ctl_valid = 1'b0;
    logic signed [15:0] ar = '0, ai = '0, br = '0, bi = '0;
    logic [7:0] ctl = '0;

    logic        ov [NDUT];
    logic [15:0] qr [NDUT];
    logic [15:0] qi [NDUT];

    int    n_chk = 0, n_err = 0;
    longint cyc = 0;

    logic        exp_v [NDUT][RING];
    logic [15:0] exp_r [NDUT][RING];
    logic [15:0] exp_i [NDUT][RING];

    // 0 round/external, 1 truncate, 2 toward zero, 3 away, 4 even
    string tag [NDUT] = '{"R1,R3,R5,R6,R7", "R1,R3,R4", "R1,R3,R5,R6,R8",
                          "R1,R3,R5,R6,R9", "R1,R3,R5,R6,R10"};

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cmult_dither dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_ar(ar), .in_ai(ai), .in_br(br), .in_bi(bi),
        .ctl_valid(ctl_valid), .ctl_data(ctl),
        .out_valid(ov[0]), .out_r(qr[0]), .out_i(qi[0])
    );

    for (genvar k = 1; k < NDUT; k++) begin : g_var
        localparam bit RE = (k != 1);
        localparam carry_src_e CS = carry_src_e'((k == 2) ? 1 : (k == 3) ? 2 : (k == 4) ? 3 : 0);
        cmult_dither #(.ROUND_EN(RE), .CARRY_SRC(CS)) u_var (
            .clk(clk), .rst(rst), .in_valid(in_valid),
            .in_ar(ar), .in_ai(ai), .in_br(br), .in_bi(bi),
            .ctl_valid(ctl_valid), .ctl_data(ctl),
            .out_valid(ov[k]), .out_r(qr[k]), .out_i(qi[k])
        );
    end

    // reference: D = 17 discarded bits, constant 2^16 - 1
    function automatic logic [15:0] model(input int k, input longint p, input bit cext);
        longint kept, c;
        kept = p >>> 17;
        if (k == 1) return 16'(kept);
        case (k)
            0:       c = cext;
            2:       c = (p < 0) ? 1 : 0;
            3:       c = (p >= 0) ? 1 : 0;
            default: c = kept & 1;
        endcase
        return 16'((p + 65535 + c) >>> 17);
    endfunction

    task automatic check_outputs();
        for (int k = 0; k < NDUT; k++) begin
            int s = int'(cyc % RING);
            n_chk++;
            if (exp_v[k][s]) begin
                if (ov[k] !== 1'b1 || qr[k] !== exp_r[k][s] || qi[k] !== exp_i[k][s]) begin
                    n_err++;
                    $display("FAIL %s dut%0d cyc %0d: got v=%b r=%h i=%h exp v=1 r=%h i=%h",
                             tag[k], k, cyc, ov[k], qr[k], qi[k], exp_r[k][s], exp_i[k][s]);
                end
                exp_v[k][s] = 1'b0;
            end else if (ov[k] !== 1'b0) begin
                n_err++;
                $display("FAIL R2,R3 dut%0d cyc %0d: got v=%b exp v=0", k, cyc, ov[k]);
            end
        end
    endtask

    task automatic cycle(input logic signed [15:0] a_r, a_i, b_r, b_i,
                         input logic iv, cv, input logic [7:0] cw);
        @(negedge clk);
        check_outputs();
        ar = a_r; ai = a_i; br = b_r; bi = b_i;
        in_valid = iv; ctl_valid = cv; ctl = cw;
        if (iv && cv) begin
            longint pr, pim;
            pr  = longint'(a_r) * longint'(b_r) - longint'(a_i) * longint'(b_i);
            pim = longint'(a_r) * longint'(b_i) + longint'(a_i) * longint'(b_r);
            for (int k = 0; k < NDUT; k++) begin
                int s = int'((cyc + 1 + ((k == 1) ? 3 : 4)) % RING);
                exp_v[k][s] = 1'b1;
                exp_r[k][s] = model(k, pr, cw[0]);
                exp_i[k][s] = model(k, pim, cw[0]);
            end
        end
    endtask

    task automatic send(input logic signed [15:0] a_r, a_i, b_r, b_i, input logic [7:0] cw);
        cycle(a_r, a_i, b_r, b_i, 1'b1, 1'b1, cw);
    endtask

    initial begin
        for (int k = 0; k < NDUT; k++)
            for (int s = 0; s < RING; s++) exp_v[k][s] = 1'b0;
        repeat (2) @(posedge clk);
        // R11: outputs quiet while in reset
        @(negedge clk);
        for (int k = 0; k < NDUT; k++) begin
            n_chk++;
            if (ov[k] !== 1'b0) begin
                n_err++;
                $display("FAIL R11 dut%0d: got v=%b exp v=0", k, ov[k]);
            end
        end
        rst = 1'b0;
        repeat (6) cycle(0, 0, 0, 0, 1'b0, 1'b0, 8'h00);

        // R6 R8 R9 R10: exact halves of both signs, odd and even kept parts, both carries
        for (int cbit = 0; cbit < 2; cbit++) begin
            send(256, 0, 256, 0, 8'(cbit));      // real +0.5
            send(768, 0, 256, 0, 8'(cbit));      // real +1.5
            send(-256, 0, 256, 0, 8'(cbit));     // real -0.5
            send(-768, 0, 256, 0, 8'(cbit));     // real -1.5
            send(256, 0, 0, 256, 8'(cbit));      // imag +0.5
            send(0, 256, 0, -256, 8'(cbit));     // real +0.5 through ai*bi
            send(255, 0, 256, 0, 8'(cbit));      // R5 just below half
            send(257, 0, 256, 0, 8'(cbit));      // R5 just above half
            send(-255, 0, 256, 0, 8'(cbit));
            send(-257, 0, 256, 0, 8'(cbit));
        end
        // R7: upper control bits ignored
        send(256, 256, 256, 256, 8'hFE);
        send(256, 256, 256, 256, 8'hFF);
        // R1: extremes
        send(-32768, -32768, -32768, -32768, 8'h01);
        send(32767, 32767, 32767, 32767, 8'h00);
        send(-32768, 32767, 32767, -32768, 8'h01);
        // R2: lone valids produce nothing
        cycle(100, 200, 300, 400, 1'b1, 1'b0, 8'h01);
        cycle(100, 200, 300, 400, 1'b0, 1'b1, 8'h01);
        repeat (6) cycle(0, 0, 0, 0, 1'b0, 1'b0, 8'h00);

        // random traffic with gaps
        for (int n = 0; n < 3000; n++) begin
            cycle(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                  1'(($urandom % 4) != 0), 1'(($urandom % 4) != 0), 8'($urandom));
        end
        repeat (8) cycle(0, 0, 0, 0, 1'b0, 1'b0, 8'h00);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule